// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter Chain

This block is a wide synchronous up-counter built from a chain of identical 4-bit slices. Each slice counts, loads or holds on the rising clock edge, and each one is cleared at once by an active-low asynchronous clear. Every slice also raises a terminal-count flag when it holds all ones and its trickle enable is high. That flag feeds the trickle enable of the next slice up, so the upper slices only advance when every slice below them is about to wrap.

The parallel-enable signal (load, active low), the parallel count enable and the load data reach all slices in the same cycle, so the full-width value is preset on one edge. The last slice's terminal count is the wrap flag of the whole counter. It is high exactly when every bit is one and the external trickle enable is high. All pins are plain level controls with no handshake: the counter samples them on every rising edge and never applies back-pressure.

Top module: `cascade_counter`

## Requirements
- R1: While clear_n is low, every count bit is 0 at once, with no clock edge needed. This holds whatever the levels of load_n, enp, ent and the clock.
- R2: tc_out is 0 whenever clear_n is low.
- R3: With clear_n high, load_n low at a rising edge copies all of load_data into count on that single edge, whatever the levels of enp and ent.
- R4: With clear_n and load_n high and both enp and ent high, count rises by one at each rising edge. It wraps from all ones to zero across the full width.
- R5: With load_n high, count keeps its value at a rising edge if enp is low or ent is low.
- R6: tc_out is 1 only when ent is 1 and every count bit is 1. It follows ent combinationally, without waiting for an edge.
- R7: enp has no effect on tc_out.
- R8: Slice k+1 (bits 4k+7 down to 4k+4) changes on a counting edge only when all bits below it are ones, so a carry crosses each slice boundary on the correct edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| enp | input | 1 | Parallel count enable, shared by all slices |
| ent | input | 1 | Trickle count enable into the lowest slice |
| load_data | input | STAGES*SLICE_W | Preset value, lowest slice in the low bits |
| count | output | STAGES*SLICE_W | Current count |
| tc_out | output | 1 | Terminal count of the last slice (full-width wrap flag) |

## Verification
Load, count and hold results appear one rising edge after the inputs are set. The bench drives inputs on the falling edge, lets one rising edge pass, and compares on the next falling edge. Clear and tc_out have no register in their path. The bench changes clear_n, ent or enp in the middle of a cycle and compares 1 ns later, before any edge can hide a mistake. It also compares again after an edge has passed with clear_n still low.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } slice_op_e;

  function automatic slice_op_e pick_op(input logic load_n, input logic enp, input logic ent);
    if (!load_n)          return OP_LOAD;
    else if (enp && ent)  return OP_COUNT;
    else                  return OP_HOLD;
  endfunction
endpackage

// File: rtl/ctr_slice_next.sv
module ctr_slice_next
  import ctr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         load_n,
  input  logic         enp,
  input  logic         ent,
  input  logic [W-1:0] d,
  input  logic [W-1:0] q,
  output logic [W-1:0] q_next
);
  slice_op_e op;

  always_comb begin
    op = pick_op(load_n, enp, ent);
    unique case (op)
      OP_LOAD:  q_next = d;
      OP_COUNT: q_next = q + W'(1);
      default:  q_next = q;
    endcase
  end
endmodule

// File: rtl/ctr_slice.sv
module ctr_slice #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic         load_n,
  input  logic         enp,
  input  logic         ent,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         tc
);
  logic [W-1:0] q_next;

  ctr_slice_next #(.W(W)) u_next (
    .load_n (load_n),
    .enp    (enp),
    .ent    (ent),
    .d      (d),
    .q      (q),
    .q_next (q_next)
  );

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) q <= '0;
    else          q <= q_next;
  end

  assign tc = ent & (&q);

  assert_load_copies_R3: assert property (@(posedge clk) disable iff (!clear_n)
    !load_n |=> q == $past(d));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && enp && ent) |=> q == W'($past(q) + W'(1)));

  assert_hold_value_R5: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && !(enp && ent)) |=> $stable(q));
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int STAGES  = 3,
  parameter int SLICE_W = 4
) (
  input  logic                       clk,
  input  logic                       clear_n,
  input  logic                       load_n,
  input  logic                       enp,
  input  logic                       ent,
  input  logic [STAGES*SLICE_W-1:0]  load_data,
  output logic [STAGES*SLICE_W-1:0]  count,
  output logic                       tc_out
);
  localparam int TOTAL_W = STAGES * SLICE_W;

  logic [STAGES:0] carry;
  assign carry[0] = ent;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    ctr_slice #(.W(SLICE_W)) u_slice (
      .clk     (clk),
      .clear_n (clear_n),
      .load_n  (load_n),
      .enp     (enp),
      .ent     (carry[k]),
      .d       (load_data[k*SLICE_W +: SLICE_W]),
      .q       (count[k*SLICE_W +: SLICE_W]),
      .tc      (carry[k+1])
    );

    if (k > 0) begin : g_carry_chk
      assert_carry_boundary_R8: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && !(&count[k*SLICE_W-1:0])) |=> $stable(count[k*SLICE_W +: SLICE_W]));
    end
  end

  assign tc_out = carry[STAGES];

  assert_tc_needs_full_R6: assert property (@(posedge clk) disable iff (!clear_n)
    tc_out |-> (ent && count == {TOTAL_W{1'b1}}));

  assert_tc_when_full_R6: assert property (@(posedge clk) disable iff (!clear_n)
    (ent && count == {TOTAL_W{1'b1}}) |-> tc_out);
endmodule

// File: tb/cascade_counter_tb.sv
module cascade_counter_tb;
  localparam int STAGES  = 3;
  localparam int SLICE_W = 4;
  localparam int TW      = STAGES * SLICE_W;
  localparam int NVEC    = 16;

  // {load_n, enp, ent, load_data[11:0], expected count[11:0]}
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 12'h00C, 12'h00C},
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h00D},
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h00E},
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h00F},
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h010},
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h011},
    {1'b1, 1'b0, 1'b1, 12'h000, 12'h011},
    {1'b1, 1'b1, 1'b0, 12'h000, 12'h011},
    {1'b0, 1'b0, 1'b0, 12'h0FE, 12'h0FE},
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h0FF},
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h100},
    {1'b0, 1'b1, 1'b1, 12'hFFE, 12'hFFE},
    {1'b1, 1'b1, 1'b1, 12'h000, 12'hFFF},
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h000},
    {1'b0, 1'b0, 1'b1, 12'h5A3, 12'h5A3},
    {1'b1, 1'b0, 1'b0, 12'h000, 12'h5A3}
  };

  logic          clk = 1'b0;
  logic          clear_n = 1'b0;
  logic          load_n = 1'b1;
  logic          enp = 1'b0;
  logic          ent = 1'b0;
  logic [TW-1:0] load_data = '0;
  logic [TW-1:0] count;
  logic          tc_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cascade_counter #(.STAGES(STAGES), .SLICE_W(SLICE_W)) u_dut (
    .clk       (clk),
    .clear_n   (clear_n),
    .load_n    (load_n),
    .enp       (enp),
    .ent       (ent),
    .load_data (load_data),
    .count     (count),
    .tc_out    (tc_out)
  );

  task automatic check(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // reset state (R1, R2)
    @(negedge clk);
    check("R1 reset count", count, '0);
    check("R2 reset tc", TW'(tc_out), '0);
    clear_n = 1'b1;

    // table walk: one edge per row, compared on the following falling edge
    for (int i = 0; i < NVEC; i++) begin
      logic [26:0] v;
      string tag;
      v = VEC[i];
      load_n    = v[26];
      enp       = v[25];
      ent       = v[24];
      load_data = v[23:12];
      if (!v[26])               tag = "R3 load";
      else if (v[25] && v[24])  tag = "R4/R8 count";
      else                      tag = "R5 hold";
      @(posedge clk);
      @(negedge clk);
      check(tag, count, v[11:0]);
      check("R6 tc row", TW'(tc_out), TW'(v[24] && v[11:0] == 12'hFFF));
    end

    // preset all ones, then probe tc without edges (R6, R7)
    load_n = 1'b0; load_data = 12'hFFF; enp = 1'b0; ent = 1'b0;
    @(posedge clk); @(negedge clk);
    load_n = 1'b1;
    check("R3 load ones", count, 12'hFFF);
    check("R6 tc low with ent low", TW'(tc_out), '0);
    ent = 1'b1; #1;
    check("R6 tc rises with ent", TW'(tc_out), 1);
    enp = 1'b1; #1;
    check("R7 tc with enp high", TW'(tc_out), 1);
    enp = 1'b0; #1;
    check("R7 tc with enp low", TW'(tc_out), 1);
    ent = 1'b0; #1;
    check("R6 tc drops with ent", TW'(tc_out), '0);
    ent = 1'b1; #1;

    // mid-cycle asynchronous clear (R1, R2)
    clear_n = 1'b0; #1;
    check("R1 mid-cycle clear", count, '0);
    check("R2 tc under clear", TW'(tc_out), '0);
    load_n = 1'b0; enp = 1'b1; load_data = 12'hABC;
    @(posedge clk); @(negedge clk);
    check("R1 clear beats load", count, '0);
    clear_n = 1'b1; load_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R4 count after clear", count, 12'h001);

    finish_run();
  end
endmodule